// File: doc/BRIEF.md
# Burst Address Generator with Dual Orders

This block produces the address presented to the array of a synchronous burst SRAM on every clock. A full external address is captured when either of two active-low load strobes fires. One strobe comes from the processor side and the other from the memory controller side, and they have different priorities. Once an address is loaded, the advance strobe steps the two least significant address bits through a four-beat burst. The other address bits stay fixed for the whole burst.

The burst order is chosen with an order-select pin when the address is loaded. Low selects linear order: the low bits count up modulo 4 from the start value. High selects interleaved order: beat k uses the start bits XOR k. With both load strobes idle, the burst advances when the advance strobe is low and is suspended when it is high. After four beats the sequence returns to the start value without a reload. A valid flag shows whether a loaded address is currently in use.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after its release with no strobe applied, `addr` is all zeros and `valid` is 0.
- R2: A clock edge with `lds_p_n` low and `ce_n` low loads `ext_addr` into `addr` and sets `valid` to 1. This applies whatever the level of `lds_c_n` and `adv_n`.
- R3: A clock edge with `lds_p_n` high, `lds_c_n` low and `ce_n` low loads `ext_addr` into `addr` and sets `valid` to 1.
- R4: The processor strobe takes priority over the controller strobe. A clock edge with `lds_p_n` low and `ce_n` high leaves `addr` and `valid` unchanged, even when `lds_c_n` is also low.
- R5: A clock edge with `lds_p_n` high, `lds_c_n` low and `ce_n` high is a deselect. It clears `valid` and leaves `addr` unchanged.
- R6: In linear order (`order_sel` 0 at load), each advance (both load strobes high, `adv_n` low, `valid` 1) sets the low two bits of `addr` to (start + k) mod 4 for beat k. For example, start 2 gives 2, 3, 0, 1.
- R7: In interleaved order (`order_sel` 1 at load), beat k sets the low two bits to start XOR k. For example, start 1 gives 1, 0, 3, 2.
- R8: The fifth address of an uninterrupted burst equals the loaded start value, and the sequence then repeats.
- R9: A clock edge with both load strobes high and `adv_n` high holds `addr` and `valid`.
- R10: The burst order is fixed by `order_sel` at load time. Changing `order_sel` during a burst does not change the sequence.
- R11: While `valid` is 0, an advance cycle leaves `addr` unchanged and `valid` at 0.
- R12: Bits `addr[AW-1:2]` never change except on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | AW | External address sampled on a load |
| ce_n | input | 1 | Active-low chip enable |
| lds_p_n | input | 1 | Processor-side load strobe, active low, higher priority |
| lds_c_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Advance strobe, active low |
| order_sel | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | output | AW | Current burst address |
| valid | output | 1 | A loaded address is active |

## Verification
The assertions assume that every control input has a known level at each clock edge after reset, and that `ext_addr` is stable at the edge where it is sampled. The stimulus changes inputs only on the falling clock edge and draws every strobe, enable and order bit from seeded random values, so every strobe combination appears, including both strobes low with the chip disabled. Directed sequences add full wrapping bursts in both orders, a mid-burst order change, and loads whose upper bits are all ones.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          ce_n,
  input  logic          lds_p_n,
  input  logic          lds_c_n,
  input  logic          adv_n,
  input  logic          order_sel,
  output logic [AW-1:0] addr,
  output logic          valid
);
  localparam int UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    start_q, beat_q;
  logic          ord_q, valid_q;
  logic [1:0]    low;

  wire load_p = !lds_p_n && !ce_n;
  wire hold_p = !lds_p_n && ce_n;
  wire load_c = lds_p_n && !lds_c_n && !ce_n;
  wire desel  = lds_p_n && !lds_c_n && ce_n;
  wire step   = lds_p_n && lds_c_n && !adv_n && valid_q;

  assign low   = ord_q ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr  = {upper_q, low};
  assign valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      ord_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (load_p || load_c) begin
      upper_q <= ext_addr[AW-1:2];
      start_q <= ext_addr[1:0];
      beat_q  <= '0;
      ord_q   <= order_sel;
      valid_q <= 1'b1;
    end else if (desel) begin
      valid_q <= 1'b0;
    end else if (step) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  AST_LOAD_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    (!lds_p_n && !ce_n) |=> (addr == $past(ext_addr) && valid)); // R2
  AST_LOAD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (lds_p_n && !lds_c_n && !ce_n) |=> (addr == $past(ext_addr) && valid)); // R3
  AST_PROC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!lds_p_n && ce_n) |=> ($stable(addr) && $stable(valid))); // R4
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (lds_p_n && !lds_c_n && ce_n) |=> (!valid && $stable(addr))); // R5
  AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (lds_p_n && lds_c_n && adv_n) |=> ($stable(addr) && $stable(valid))); // R9
  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (lds_p_n && lds_c_n && !valid) |=> (!valid && $stable(addr))); // R11
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (lds_p_n && lds_c_n) |=> (addr[AW-1:2] == $past(addr[AW-1:2]))); // R12
  AST_HOLD_NOLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_p |=> $stable(upper_q)); // R4
endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          ce_n = 1'b1, lds_p_n = 1'b1, lds_c_n = 1'b1, adv_n = 1'b1, order_sel = 1'b0;
  logic [AW-1:0] addr;
  logic          valid;

  int checks = 0, failures = 0;

  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_start = '0, m_beat = '0;
  logic          m_ord = 1'b0, m_valid = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .ce_n(ce_n),
    .lds_p_n(lds_p_n), .lds_c_n(lds_c_n), .adv_n(adv_n),
    .order_sel(order_sel), .addr(addr), .valid(valid));

  function automatic logic [1:0] beat_low(logic [1:0] s, logic [1:0] k, logic o);
    return o ? (s ^ k) : (s + k);
  endfunction

  function automatic logic [AW-1:0] m_addr();
    return {m_up, beat_low(m_start, m_beat, m_ord)};
  endfunction

  task automatic chk(string tag, logic [AW-1:0] ea, logic ev);
    checks++;
    if (addr !== ea || valid !== ev) begin
      failures++;
      $display("FAIL %s addr=%h exp=%h valid=%b exp=%b", tag, addr, ea, valid, ev);
    end
  endtask

  function automatic string kind(logic ce, logic p, logic c, logic adv);
    if (!p)       return ce ? "R4" : "R2";
    if (!c)       return ce ? "R5" : "R3";
    if (!m_valid) return "R11";
    if (adv)      return "R9";
    return m_ord ? "R7" : "R6";
  endfunction

  task automatic cyc(logic [AW-1:0] a, logic ce, logic p, logic c, logic adv, logic o, string tag = "");
    string t;
    @(negedge clk);
    ext_addr = a; ce_n = ce; lds_p_n = p; lds_c_n = c; adv_n = adv; order_sel = o;
    t = (tag == "") ? kind(ce, p, c, adv) : tag;
    @(posedge clk);
    if ((!p && !ce) || (p && !c && !ce)) begin
      m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = '0; m_ord = o; m_valid = 1'b1;
    end else if (p && !c && ce) begin
      m_valid = 1'b0;
    end else if (p && c && !adv && m_valid) begin
      m_beat = m_beat + 2'd1;
    end
    #1;
    chk(t, m_addr(), m_valid);
  endtask

  initial begin
    int cnt = 0;
    while (cnt < 100000) begin @(posedge clk); cnt++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0] lin_exp [5];
    logic [1:0] int_exp [5];
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 chk("R1", '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc('0, 1, 1, 1, 1, 0, "R1");

    // R11: advance without a loaded address
    cyc(20'h12345, 0, 1, 1, 0, 0, "R11");

    // R6 and R8: linear start 2 gives 2,3,0,1,2
    lin_exp = '{2'd2, 2'd3, 2'd0, 2'd1, 2'd2};
    cyc(20'hABCD2, 0, 0, 1, 1, 0, "R2");
    if (addr[1:0] !== lin_exp[0]) begin failures++; $display("FAIL R6 low=%0d exp=%0d", addr[1:0], lin_exp[0]); end
    checks++;
    for (int k = 1; k < 5; k++) begin
      cyc(20'h0, 1, 1, 1, 0, 0, (k == 4) ? "R8" : "R6");
      checks++;
      if (addr[1:0] !== lin_exp[k]) begin failures++; $display("FAIL %s low=%0d exp=%0d", (k == 4) ? "R8" : "R6", addr[1:0], lin_exp[k]); end
    end

    // R7 and R8: interleaved start 1 gives 1,0,3,2,1, with R10 order toggling
    int_exp = '{2'd1, 2'd0, 2'd3, 2'd2, 2'd1};
    cyc(20'h55551, 0, 1, 0, 1, 1, "R3");
    for (int k = 1; k < 5; k++) begin
      cyc(20'h0, 1, 1, 1, 0, k[0], "R10");
      checks++;
      if (addr[1:0] !== int_exp[k]) begin failures++; $display("FAIL R7 low=%0d exp=%0d", addr[1:0], int_exp[k]); end
    end

    // R9: suspend mid-burst
    cyc(20'h0, 0, 1, 1, 1, 0, "R9");
    // R4: both strobes low with chip disabled
    cyc(20'hFFFFF, 1, 0, 0, 0, 0, "R4");
    // R12: upper bits all ones, linear wrap from 3 to 0 keeps upper bits
    cyc(20'hFFFFF, 0, 1, 0, 1, 0, "R3");
    cyc(20'h0, 1, 1, 1, 0, 0, "R12");
    checks++;
    if (addr !== 20'hFFFFC) begin failures++; $display("FAIL R12 addr=%h exp=%h", addr, 20'hFFFFC); end
    // R5: deselect, then R11 advance is ignored
    cyc(20'h0, 1, 1, 0, 1, 0, "R5");
    cyc(20'h0, 1, 1, 1, 0, 0, "R11");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc($urandom, r[0] & r[1], (r[4:2] != 0), (r[7:5] > 2), r[8] & r[9], r[10]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule